// File: doc/BRIEF.md
# Frame-Synchronous Byte-Parallel Descrambler

This block removes the frame-synchronous scrambling from a byte-wide SONET/SDH line stream. The keystream comes from a seven-stage linear feedback generator with polynomial 1 + x^6 + x^7, which has a period of 127 bits. The block produces eight keystream bits on every clock. Each incoming byte is XORed with those bits, with the most significant bit taking the first keystream bit. The result leaves the block through an output register, one clock after the byte enters.

A frame counter outside the block supplies a two-bit position code with every byte. One code reloads the generator with all ones on the first byte after the row-1 overhead. One code marks framing and trace bytes, which go through unchanged while the generator waits. The remaining code lets the generator run for the rest of the frame. A separate enable input turns descrambling off, so that bytes go through unchanged. The generator keeps its place in the frame while descrambling is off. Finding the frame is left to other logic.

Top module: `fsync_descrambler`

## Requirements
- R1: While `rstN` is low, `outByte` is 0x00 and the generator holds all ones.
- R2: Every result appears on `outByte` exactly one clock after its byte is presented on `inByte`.
- R3: Position code 2'b10 (seed) loads the generator with all ones for that byte. The byte is XORed with keystream 11111110, MSB first, so an input of 0x00 gives 0xFE.
- R4: The keystream follows 1 + x^6 + x^7. Output bit = stage 7; the feedback into stage 1 is stage 7 XOR stage 6. The keystream repeats every 127 bits, so the byte 127 bytes after a seed byte also sees 0xFE.
- R5: Position code 2'b00 (run) advances the generator eight steps per byte without pause, and the byte is XORed with those eight bits, MSB first.
- R6: Position codes 2'b01 and 2'b11 (overhead hold) pass the byte unchanged and leave the generator state untouched.
- R7: With `descrEn` low, every byte passes unchanged. The generator still seeds and advances as the position code directs.
- R8: Scrambling with the same keystream and then running the result through the block returns the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descrEn | input | 1 | 1 = descramble, 0 = bypass |
| posCode | input | 2 | Frame position: 00 run, 01/11 hold, 10 seed |
| inByte | input | 8 | Scrambled byte in |
| outByte | output | 8 | Descrambled byte out, registered |

## Verification
On every clock the assertions check four things. Hold and bypass bytes come out unchanged one clock later. A seed byte comes out XORed with 0xFE. The generator never changes during a hold and never reaches the all-zero state. Only the bench scenarios can show that the run keystream follows the right polynomial across byte boundaries, that it repeats after 127 bits, and that it picks up in the right place after holds and bypass stretches. They also show that the block undoes the scrambling. The bench checks all of this against its own bit-serial model of the generator.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int BYTE_W = 8;
  localparam int GEN_LEN = 7;
  localparam int GEN_TAP = 6;

  localparam logic [1:0] POS_RUN  = 2'b00;
  localparam logic [1:0] POS_SEED = 2'b10;

  typedef struct packed {
    logic seedLoad;
    logic genAdvance;
    logic passThru;
  } fsdCtrl_t;
endpackage

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
(
  input  logic       descrEn,
  input  logic [1:0] posCode,
  output fsdCtrl_t   ctrl
);
  always_comb begin
    ctrl.seedLoad   = (posCode == POS_SEED);
    ctrl.genAdvance = (posCode == POS_RUN);
    // odd codes mark overhead bytes that must not be touched
    ctrl.passThru   = !descrEn || posCode[0];
  end
endmodule

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
#(
  parameter int WIDTH = BYTE_W,
  parameter int LEN   = GEN_LEN,
  parameter int TAP   = GEN_TAP
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsdCtrl_t         ctrl,
  input  logic [WIDTH-1:0] inByte,
  output logic [WIDTH-1:0] outByte,
  output logic [LEN-1:0]   genState
);
  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0]   walk;
  logic [LEN-1:0]   genNext;
  logic [WIDTH-1:0] keyByte;

  // unroll WIDTH serial steps; first bit produced lands on the MSB
  always_comb begin
    walk = ctrl.seedLoad ? SEED : genState;
    keyByte = '0;
    for (int i = 0; i < WIDTH; i++) begin
      keyByte[WIDTH-1-i] = walk[LEN-1];
      walk = {walk[LEN-2:0], walk[LEN-1] ^ walk[TAP-1]};
    end
    genNext = walk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genState <= SEED;
      outByte  <= '0;
    end else begin
      if (ctrl.seedLoad || ctrl.genAdvance) genState <= genNext;
      outByte <= ctrl.passThru ? inByte : (inByte ^ keyByte);
    end
  end
endmodule

// File: rtl/fsync_descrambler.sv
module fsync_descrambler
  import fsd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descrEn,
  input  logic [1:0] posCode,
  input  logic [7:0] inByte,
  output logic [7:0] outByte
);
  fsdCtrl_t ctrl;
  logic [GEN_LEN-1:0] genState;

  fsd_ctrl u_ctrl (
    .descrEn (descrEn),
    .posCode (posCode),
    .ctrl    (ctrl)
  );

  fsd_datapath #(
    .WIDTH (BYTE_W),
    .LEN   (GEN_LEN),
    .TAP   (GEN_TAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inByte   (inByte),
    .outByte  (outByte),
    .genState (genState)
  );
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       descrEn,
  input logic [1:0] posCode,
  input logic [7:0] inByte,
  input logic [7:0] outByte,
  input logic [6:0] genState
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (outByte == 8'h00 && genState == 7'h7F));

  // R6: overhead bytes pass through
  a_r6_hold_passthru: assert property (@(posedge clk) disable iff (!rstN)
    posCode[0] |=> outByte == $past(inByte));

  // R6: generator frozen
  a_r6_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    posCode[0] |=> $stable(genState));

  // R7
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !descrEn |=> outByte == $past(inByte));

  // R3
  a_r3_seed_key: assert property (@(posedge clk) disable iff (!rstN)
    (descrEn && posCode == 2'b10) |=> outByte == ($past(inByte) ^ 8'hFE));

  // R4: the generator can never lock up in the all-zero state
  a_r4_no_zero_state: assert property (@(posedge clk) disable iff (!rstN)
    genState != 7'h00);
endmodule

bind fsync_descrambler fsd_checker u_fsd_chk (
  .clk      (clk),
  .rstN     (rstN),
  .descrEn  (descrEn),
  .posCode  (posCode),
  .inByte   (inByte),
  .outByte  (outByte),
  .genState (genState)
);

// File: tb/tb_fsync_descrambler.sv
module tb_fsync_descrambler;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       descrEn = 1'b1;
  logic [1:0] posCode = 2'b01;
  logic [7:0] inByte = 8'h00;
  logic [7:0] outByte;

  int checks = 0;
  int fails = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [6:0] refState = 7'h7F;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_descrambler dut (
    .clk(clk), .rstN(rstN), .descrEn(descrEn),
    .posCode(posCode), .inByte(inByte), .outByte(outByte)
  );

  // bit-serial model: out = stage7, feedback = stage7 ^ stage6
  function automatic logic [7:0] keyFrom(input logic [6:0] st, output logic [6:0] stOut);
    logic [7:0] k;
    logic [6:0] s;
    s = st;
    for (int i = 0; i < 8; i++) begin
      k = {k[6:0], s[6]};
      s = {s[5:0], s[6] ^ s[5]};
    end
    stOut = s;
    return k;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: preScr=1 scrambles data with the model keystream first (R8)
  task automatic sendByte(input logic [1:0] code, input logic en,
                          input logic [7:0] data, input bit preScr, input string tag);
    logic [7:0] ks;
    logic [6:0] nxt;
    logic [7:0] exp;
    logic [7:0] drv;
    ks = 8'h00;
    if (code == 2'b10) refState = 7'h7F;
    if (code == 2'b00 || code == 2'b10) begin
      ks = keyFrom(refState, nxt);
      refState = nxt;
    end
    drv = preScr ? (data ^ ks) : data;
    exp = (code[0] || !en) ? drv : (drv ^ ks);
    @(negedge clk);
    posCode = code;
    descrEn = en;
    inByte = drv;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) check(tagQ.pop_front(), outByte, expQ.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset output", outByte, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R3: seed byte of zeros gives the first keystream byte
    sendByte(2'b10, 1'b1, 8'h00, 0, "R3 seed key FE");
    // R5: continuous run
    sendByte(2'b00, 1'b1, 8'h00, 0, "R5 run byte 1");
    sendByte(2'b00, 1'b1, 8'hA5, 0, "R5 run byte 2");
    sendByte(2'b00, 1'b1, 8'h3C, 0, "R2 latency run byte 3");
    // R6: overhead hold, then resume
    sendByte(2'b01, 1'b1, 8'hF6, 0, "R6 hold A1");
    sendByte(2'b01, 1'b1, 8'h28, 0, "R6 hold A2");
    sendByte(2'b11, 1'b1, 8'h01, 0, "R6 hold code 11");
    sendByte(2'b00, 1'b1, 8'h00, 0, "R6 resume after hold");
    // R7: bypass while generator keeps running
    sendByte(2'b00, 1'b0, 8'h5A, 0, "R7 bypass run");
    sendByte(2'b00, 1'b0, 8'hC3, 0, "R7 bypass run 2");
    sendByte(2'b10, 1'b0, 8'h77, 0, "R7 bypass seed");
    sendByte(2'b00, 1'b1, 8'h00, 0, "R7 re-enable aligned");

    // R4: period 127 -> byte 127 after a seed repeats FE
    sendByte(2'b10, 1'b1, 8'h00, 0, "R4 seed");
    for (int i = 1; i < 127; i++) sendByte(2'b00, 1'b1, 8'h00, 0, "R4 run sequence");
    @(negedge clk);
    posCode = 2'b00; descrEn = 1'b1; inByte = 8'h00;
    expQ.push_back(8'hFE);
    tagQ.push_back("R4 period repeat FE");
    refState = 7'h00;

    // R8: scramble then descramble restores data
    sendByte(2'b10, 1'b1, 8'h12, 1, "R8 restore seed");
    for (int i = 0; i < 40; i++)
      sendByte(2'b00, 1'b1, 8'((i * 37 + 11) & 8'hFF), 1, "R8 restore run");

    @(negedge clk);
    posCode = 2'b01;
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule